// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of the two-wire PHY management bus. It drives a management clock output and a bidirectional data line, split into an output, an output enable and an input. Software starts a transaction by writing a single 32-bit command word. That word holds the register address, the PHY address, an opcode and, for a write, 16 data bits. The block then shifts out the whole serial frame without further help. When the transaction ends it raises a ready flag in the same word. Software polls that word for completion, and for a read it also finds the captured 16 data bits in the low half.

A read hands the data line over to the PHY once the header has gone out. The block then checks that the PHY pulls the line low in the second turnaround slot. It captures sixteen data bits and issues one further idle clock before it finishes. The management clock rate is set by a parameter, `DIV_HALF`, which is the number of system clocks per clock half-period.

Top module: `mdio_master`

## Requirements
- R1: Every accepted command first shifts out 32 bits of logic 1 on `mdio_o` with `mdio_oe` high, one bit per `mdc` period. `mdio_o` changes only while `mdc` is low.
- R2: The 14 bits after the preamble are sent MSB first. They are start-of-frame `01`, then the opcode (`01` write, `10` read), then the 5-bit PHY address, then the low 5 bits of the register address.
- R3: A write next sends the turnaround pattern `10` and then the 16 data bits MSB first, with `mdio_oe` high throughout. The transaction is 64 `mdc` periods in total.
- R4: A read deasserts `mdio_oe` from bit 46 (the first turnaround bit) to the end of the frame. It samples `mdio_i` just before each `mdc` rise in bits 48..63, MSB first, and places the result in `cmd_rdata[15:0]`. It then issues one extra `mdc` period, so a read is 65 periods in total.
- R5: The command word is `[31]` ready, `[30]` error, `[29]` zero, `[28:27]` opcode, `[26:22]` PHY address, `[21:16]` register address (6 bits), `[15:0]` data. Ready rises when a transaction ends. Accepting a new valid command clears ready and error from the next cycle on.
- R6: During a read, the error bit is set if `mdio_i` is high when it is sampled in the second turnaround bit (bit 47).
- R7: A command whose register address exceeds 31 (bit 21 set), or whose opcode is neither `01` nor `10`, produces no `mdc` pulse. Ready and error are both set on the next cycle.
- R8: A command written while a transaction is in progress is ignored. The frame and the stored fields of the running transaction are unchanged.
- R9: `mdc` is low whenever the block is idle. Each `mdc` high phase lasts exactly `DIV_HALF` clock cycles.
- R10: After reset, `cmd_rdata` is zero and `mdc` and `mdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command and status word read back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value to drive |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value sampled from the bus |

## Verification
The interaction that needs care is a new command write arriving while a frame is still being shifted out. The rule for command acceptance and the frame sequencer then both want control of the stored fields in the same cycle. The bench provokes this by starting a write and then, a few dozen cycles in, writing a second command with a different address and data. It judges the result by decoding the full bit stream from the bus: it must carry only the first command, and the read-back word must still show the first command's fields. A second overlap happens in the error path, where a new command must clear an error flag that a failed read has just set. The bench checks this one cycle after the strobe.

// File: rtl/mdio_pkg.sv
// Shared constants for the MDIO management master.
// Assumes clause-22 frames: 32-bit preamble followed by 32 frame bits.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] TA_WR    = 2'b10;
    localparam logic [6:0] IDX_TA2     = 7'd47;
    localparam logic [6:0] IDX_TA1     = 7'd46;
    localparam logic [6:0] IDX_DATA0   = 7'd48;
    localparam logic [6:0] IDX_LAST_WR = 7'd63;
    localparam logic [6:0] IDX_LAST_RD = 7'd64;
endpackage

// File: rtl/mdio_tick_gen.sv
// Half-period timer for the management clock.
// Emits a one-cycle tick every DIV_HALF cycles while run is high; restarts when run drops.
module mdio_tick_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] CNT_END = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;

    // Count system clocks within one half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      cnt_q <= '0;
        else if (cnt_q == CNT_END) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == CNT_END);
endmodule

// File: rtl/mdio_frame_build.sv
// Assembles the 64-bit serial image of a transaction, sent MSB first.
// Assumes read frames leave the last 18 positions zero (line released).
module mdio_frame_build
    import mdio_pkg::*;
(
    input  logic        is_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [FRAME_BITS-1:0] frame
);
    logic [13:0] header;
    logic [17:0] tail;

    // Build the header and the tail of the frame.
    always_comb begin
        header = {SOF_CODE, (is_read ? OP_RD : OP_WR), phy_addr, reg_addr};
        tail   = is_read ? 18'd0 : {TA_WR, wr_data};
        frame  = {32'hFFFF_FFFF, header, tail};
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO management master driven by one command/status word.
// Assumes an external pull-up on the data line and a single PHY on the bus.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        busy_q, mdc_q, ready_q, err_q;
    logic [6:0]  idx_q;
    logic [FRAME_BITS-1:0] frame_q, frame_d;
    logic [15:0] data_q;
    logic [5:0]  reg_q;
    logic [4:0]  phy_q;
    logic [1:0]  op_q;
    logic        tick, accept, bad_cmd, is_rd;
    logic [1:0]  new_op;
    logic [6:0]  last_idx;

    assign new_op  = cmd_wdata[28:27];
    assign accept  = cmd_we && !busy_q;
    assign bad_cmd = cmd_wdata[21] || !((new_op == OP_WR) || (new_op == OP_RD));
    assign is_rd   = (op_q == OP_RD);
    assign last_idx = is_rd ? IDX_LAST_RD : IDX_LAST_WR;

    mdio_tick_gen #(.DIV_HALF(DIV_HALF)) i_tick (
        .clk(clk), .rst_n(rst_n), .run(busy_q), .tick(tick)
    );

    mdio_frame_build i_frame (
        .is_read(new_op == OP_RD),
        .phy_addr(cmd_wdata[26:22]),
        .reg_addr(cmd_wdata[20:16]),
        .wr_data(cmd_wdata[15:0]),
        .frame(frame_d)
    );

    // Command acceptance and the bit sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; mdc_q <= 1'b0; ready_q <= 1'b0; err_q <= 1'b0;
            idx_q <= '0; frame_q <= '0; data_q <= '0; reg_q <= '0;
            phy_q <= '0; op_q <= '0;
        end else if (accept) begin
            op_q    <= new_op;
            phy_q   <= cmd_wdata[26:22];
            reg_q   <= cmd_wdata[21:16];
            data_q  <= cmd_wdata[15:0];
            ready_q <= bad_cmd;
            err_q   <= bad_cmd;
            busy_q  <= !bad_cmd;
            idx_q   <= '0;
            mdc_q   <= 1'b0;
            frame_q <= bad_cmd ? '0 : frame_d;
        end else if (busy_q && tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (is_rd && idx_q == IDX_TA2 && mdio_i) err_q <= 1'b1;
                if (is_rd && idx_q >= IDX_DATA0 && idx_q <= IDX_LAST_WR)
                    data_q <= {data_q[14:0], mdio_i};
            end else begin
                mdc_q <= 1'b0;
                if (idx_q == last_idx) begin
                    busy_q  <= 1'b0;
                    ready_q <= 1'b1;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    assign mdc       = mdc_q;
    assign mdio_o    = busy_q && frame_q[FRAME_BITS-1];
    assign mdio_oe   = busy_q && !(is_rd && idx_q >= IDX_TA1);
    assign cmd_rdata = {ready_q, err_q, 1'b0, op_q, phy_q, reg_q, data_q};
endmodule

// File: rtl/mdio_master_chk.sv
// Protocol checker for mdio_master, attached by bind.
// Assumes the sequencer busy flag is brought out to it.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [31:0] cmd_wdata,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        busy
);
    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R9
    AST_READY_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[31] |-> !mdio_oe); // R5
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_we |=> $stable(cmd_rdata[28:16])); // R8
    AST_BAD_REG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !busy && cmd_wdata[21] |=> cmd_rdata[31] && cmd_rdata[30] && !busy); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !busy && !cmd_wdata[21] &&
        (cmd_wdata[28:27] == 2'b01 || cmd_wdata[28:27] == 2'b10)
        |=> !cmd_rdata[31] && !cmd_rdata[30]); // R5
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0, mdio_i;
    logic [31:0] cmd_wdata = '0, cmd_rdata;
    logic mdc, mdio_o, mdio_oe;

    int checks = 0, errors = 0;
    int rise_cnt = 0, fall_cnt = 0, hi_cyc = 0;
    int base_rise = 0, base_fall = 0, base_hi = 0;
    logic rec_o [0:2047];
    logic rec_oe[0:2047];
    logic ta2_val = 1'b0;
    logic [15:0] rd_val = '0;
    bit done = 0;

    mdio_master #(.DIV_HALF(DIV_HALF)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bus monitor: record the line at every management clock rise.
    always @(posedge mdc) begin
        if (rise_cnt < 2048) begin
            rec_o[rise_cnt]  = mdio_o;
            rec_oe[rise_cnt] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end
    always @(negedge mdc) fall_cnt = fall_cnt + 1;
    always @(posedge clk) if (mdc) hi_cyc = hi_cyc + 1;

    // PHY model: the bit slot in progress is the number of falls so far.
    always_comb begin
        int k;
        k = fall_cnt - base_fall;
        if (k == 47)                 mdio_i = ta2_val;
        else if (k >= 48 && k <= 63) mdio_i = rd_val[63 - k];
        else                         mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [5:0] rg, input logic [15:0] d);
        return {3'b000, op, phy, rg, d};
    endfunction

    // Expected line value at bit slot i, from R1..R3.
    function automatic logic exp_bit(input int i, input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
        logic [31:0] w;
        w = {2'b01, op, phy, rg, 2'b10, d};
        if (i < 32) return 1'b1;
        return w[63 - i];
    endfunction

    task automatic issue(input logic [31:0] w);
        base_rise = rise_cnt; base_fall = fall_cnt; base_hi = hi_cyc;
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wait_ready();
        for (int n = 0; n < 5000 && !cmd_rdata[31]; n++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cmd_rdata == 32'h0, "R10 rdata", cmd_rdata, 0);
        chk(!mdc && !mdio_oe, "R10 mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        int bad1, bad2, bad3, r;
        bad1 = 0; bad2 = 0; bad3 = 0;
        issue(mk(2'b01, phy, {1'b0, rg}, d));
        chk(!cmd_rdata[31] && !cmd_rdata[30], "R5 cleared on start", cmd_rdata[31:30], 0);
        wait_ready();
        r = rise_cnt - base_rise;
        chk(r == 64, "R3 write period count", r, 64);
        for (int i = 0; i < 64; i++) begin
            logic e;
            e = exp_bit(i, 2'b01, phy, rg, d);
            if (i < 32 && (rec_o[base_rise+i] !== 1'b1 || !rec_oe[base_rise+i])) bad1++;
            if (i >= 32 && i < 46 && rec_o[base_rise+i] !== e) bad2++;
            if (i >= 46 && (rec_o[base_rise+i] !== e || !rec_oe[base_rise+i])) bad3++;
        end
        chk(bad1 == 0, "R1 preamble", bad1, 0);
        chk(bad2 == 0, "R2 header", bad2, 0);
        chk(bad3 == 0, "R3 turnaround+data", bad3, 0);
        chk(cmd_rdata == {2'b10, 1'b0, 2'b01, phy, 1'b0, rg, d}, "R5 final word",
            cmd_rdata, {2'b10, 1'b0, 2'b01, phy, 1'b0, rg, d});
        chk(hi_cyc - base_hi == r * DIV_HALF && !mdc, "R9 high phase length",
            hi_cyc - base_hi, r * DIV_HALF);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input logic ta2);
        int bad_oe, bad_hdr, r;
        bad_oe = 0; bad_hdr = 0;
        rd_val = d; ta2_val = ta2;
        issue(mk(2'b10, phy, {1'b0, rg}, 16'h0));
        chk(!cmd_rdata[31] && !cmd_rdata[30], "R5 cleared on start", cmd_rdata[31:30], 0);
        wait_ready();
        r = rise_cnt - base_rise;
        chk(r == 65, "R4 read period count", r, 65);
        for (int i = 0; i < 65; i++) begin
            if (rec_oe[base_rise+i] !== (i < 46)) bad_oe++;
            if (i < 46 && rec_o[base_rise+i] !== exp_bit(i, 2'b10, phy, rg, 16'h0)) bad_hdr++;
        end
        chk(bad_oe == 0, "R4 output enable release", bad_oe, 0);
        chk(bad_hdr == 0, "R2 read header", bad_hdr, 0);
        chk(cmd_rdata[15:0] == d, "R4 captured data", cmd_rdata[15:0], d);
        chk(cmd_rdata[31] && cmd_rdata[30] == ta2, "R6 error flag", cmd_rdata[31:30], {1'b1, ta2});
        ta2_val = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int bad;
        bad = 0;
        issue(mk(2'b01, 5'h03, 6'h0A, 16'h1234));
        repeat (40) @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = mk(2'b01, 5'h1C, 6'h15, 16'hFEDC);
        @(negedge clk); cmd_we = 1'b0;
        wait_ready();
        for (int i = 0; i < 64; i++)
            if (rec_o[base_rise+i] !== exp_bit(i, 2'b01, 5'h03, 5'h0A, 16'h1234)) bad++;
        chk(bad == 0, "R8 frame untouched", bad, 0);
        chk(cmd_rdata[28:0] == mk(2'b01, 5'h03, 6'h0A, 16'h1234), "R8 fields kept",
            cmd_rdata[28:0], mk(2'b01, 5'h03, 6'h0A, 16'h1234));
    endtask

    task automatic t_reject(input logic [31:0] w, input string tag);
        issue(w);
        chk(cmd_rdata[31:30] == 2'b11, tag, cmd_rdata[31:30], 3);
        repeat (40) @(negedge clk);
        chk(rise_cnt == base_rise && !mdc && !mdio_oe, "R7 no clock", rise_cnt - base_rise, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write(5'h01, 5'h00, 16'hA5C3);
        t_write(5'h1F, 5'h1F, 16'h8001);
        t_read(5'h01, 5'h02, 16'h3C96, 1'b0);
        t_read(5'h12, 5'h11, 16'hFFFF, 1'b1);
        t_read(5'h05, 5'h1F, 16'h0001, 1'b0);
        t_busy_ignore();
        t_reject(mk(2'b01, 5'h01, 6'd32, 16'h0), "R7 reg 32 rejected");
        t_reject(mk(2'b11, 5'h01, 6'd3, 16'h0), "R7 bad opcode rejected");
        t_read(5'h00, 5'h01, 16'h5A5A, 1'b0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule